// File: doc/BRIEF.md
# Translation Context Register Bank

This block holds the software-visible state of up to sixteen address-translation contexts behind one 32-bit register port. Each context has a control word (translation enable, TLB flush request, interrupt enable), a translation-configuration word, a bus-configuration word, a 64-bit table base split over two registers, a memory-attribute word, a fault status word and a 64-bit faulting address split over two registers. The table walker and the TLB arrays sit outside; they read the per-context enable and report faults through a hardware fault port.

A fault report sets flags in the addressed context's status word. It captures the faulting address if no flag was already set. Software reads the address first and then clears the status by writing the value zero. A flush request holds the flush bit high for a fixed number of cycles, which models invalidation latency, and the bit then drops by itself. One interrupt line combines all contexts that have a fault pending and interrupts enabled.

Top module: `xlat_ctx_regbank`

## Requirements
- R1: After reset every register of every context reads zero, `ctx_xlat_en` is all zero and `irq` is low.
- R2: Control word: bit 0 is translation enable, driven onto `ctx_xlat_en[n]` one cycle after the write. Bit 2 is interrupt enable. Both read back at their positions, and bit 1 reads the flush state.
- R3: Writing control bit 1 as one sets the flush bit. It reads one for exactly FLUSH_LAT cycles after the write edge and then clears itself. Writing bit 1 as zero does not cancel a pending flush.
- R4: A fault report with flags sets status bits by OR: bit 0 translation fault, bit 1 permission fault, bit 2 walk abort, bit 4 multiple hit. Bit 3 always reads zero, and a report carrying only bit 3 changes nothing.
- R5: Writing zero to the status word clears all flags. A non-zero write leaves the flags unchanged. A fault report in the same cycle as a clear wins: status holds only the new flags.
- R6: The faulting address is captured only by a fault that finds status zero. Later faults do not overwrite it. The low half is at offset 0x30 and the high half at 0x34, and both read zero once status has been cleared.
- R7: `irq` is high when at least one context has interrupt enable set and a non-zero status.
- R8: Per-context offsets: 0x00 control, 0x08 translation config, 0x0C bus config, 0x10/0x14 table base low/high, 0x20 status, 0x28 attribute. The context stride is 0x40. Contexts 0 to 7 start at 0x000, and context n of 8 to 15 starts at 0x800 + (n-8)*0x40.
- R9: Unmapped addresses read zero and ignore writes. This covers unlisted offsets inside a context, addresses with bits 10:9 non-zero, addresses not word-aligned, and contexts at or above NUM_CTX.
- R10: The translation config, bus config, table base halves and attribute word are full 32-bit read/write registers, independent per context.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_addr | input | 12 | Register byte address |
| reg_we | input | 1 | Write strobe, sampled at the rising edge |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, combinational from `reg_addr` |
| fault_valid | input | NUM_CTX | One bit per context: a fault report this cycle |
| fault_flags | input | 5 | Fault kind flags in status-word positions |
| fault_addr | input | 64 | Faulting address |
| ctx_xlat_en | output | NUM_CTX | Per-context translation enable |
| irq | output | 1 | Combined fault interrupt |

## Verification
The hardest situation to reach is a fault report landing in the very cycle that software writes zero to the status word. A second hard case is a later fault that must leave an already captured address untouched. The directed part drives the clearing write and the fault report in the same clock, then checks that the new flags and the new address survive. The random part interleaves fault reports with non-zero and zero status writes across all contexts. This keeps the captured-address rule exercised while status is both set and clear.

// File: rtl/xlat_ctx_pkg.sv
package xlat_ctx_pkg;

    localparam int REG_W   = 32;
    localparam int ADDR_W  = 12;
    localparam int FLAG_W  = 5;
    localparam int FADDR_W = 64;
    localparam logic [FLAG_W-1:0] FLAG_MASK = 5'b10111;

    typedef enum logic [3:0] {
        SEL_NONE,
        SEL_CTRL,
        SEL_XLCFG,
        SEL_BUSCFG,
        SEL_BASE_LO,
        SEL_BASE_HI,
        SEL_FSTAT,
        SEL_ATTR,
        SEL_FADDR_LO,
        SEL_FADDR_HI
    } reg_sel_e;

endpackage

// File: rtl/xlat_ctx_decode.sv
module xlat_ctx_decode
    import xlat_ctx_pkg::*;
#(
    parameter int NUM_CTX = 16
) (
    input  logic [ADDR_W-1:0] addr,
    output logic              hit,
    output logic [3:0]        ctx_idx,
    output reg_sel_e          sel
);

    logic aligned_ok;

    always_comb begin
        ctx_idx    = {addr[11], addr[8:6]};
        aligned_ok = (addr[1:0] == 2'b00) && (addr[10:9] == 2'b00);
        case (addr[5:0])
            6'h00:   sel = SEL_CTRL;
            6'h08:   sel = SEL_XLCFG;
            6'h0C:   sel = SEL_BUSCFG;
            6'h10:   sel = SEL_BASE_LO;
            6'h14:   sel = SEL_BASE_HI;
            6'h20:   sel = SEL_FSTAT;
            6'h28:   sel = SEL_ATTR;
            6'h30:   sel = SEL_FADDR_LO;
            6'h34:   sel = SEL_FADDR_HI;
            default: sel = SEL_NONE;
        endcase
        hit = aligned_ok && (sel != SEL_NONE) && (int'(ctx_idx) < NUM_CTX);
    end

endmodule

// File: rtl/xlat_ctx_slot.sv
module xlat_ctx_slot
    import xlat_ctx_pkg::*;
#(
    parameter int FLUSH_LAT = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  reg_sel_e           sel,
    input  logic [REG_W-1:0]   wdata,
    input  logic               fault_valid,
    input  logic [FLAG_W-1:0]  fault_flags,
    input  logic [FADDR_W-1:0] fault_addr,
    output logic [REG_W-1:0]   rd_word,
    output logic               xlat_en,
    output logic               irq_req
);

    localparam int CNT_W = $clog2(FLUSH_LAT + 1);

    typedef struct packed {
        logic               en;
        logic               inten;
        logic               flush;
        logic [CNT_W-1:0]   cnt;
        logic [REG_W-1:0]   xlcfg;
        logic [REG_W-1:0]   buscfg;
        logic [REG_W-1:0]   base_lo;
        logic [REG_W-1:0]   base_hi;
        logic [REG_W-1:0]   attr;
        logic [FLAG_W-1:0]  fstat;
        logic [FADDR_W-1:0] faddr;
    } slot_t;

    slot_t st_d, st_q;
    logic  clr_wr;
    logic  flush_wr;
    logic [FLAG_W-1:0] new_flags;

    always_comb begin
        st_d      = st_q;
        clr_wr    = wr_en && (sel == SEL_FSTAT) && (wdata == '0);
        flush_wr  = wr_en && (sel == SEL_CTRL) && wdata[1];
        new_flags = fault_flags & FLAG_MASK;

        if (st_q.flush) begin
            if (st_q.cnt <= CNT_W'(1)) begin
                st_d.flush = 1'b0;
                st_d.cnt   = '0;
            end else begin
                st_d.cnt = st_q.cnt - CNT_W'(1);
            end
        end

        if (wr_en) begin
            case (sel)
                SEL_CTRL: begin
                    st_d.en    = wdata[0];
                    st_d.inten = wdata[2];
                    if (wdata[1]) begin
                        st_d.flush = 1'b1;
                        st_d.cnt   = CNT_W'(FLUSH_LAT);
                    end
                end
                SEL_XLCFG:   st_d.xlcfg   = wdata;
                SEL_BUSCFG:  st_d.buscfg  = wdata;
                SEL_BASE_LO: st_d.base_lo = wdata;
                SEL_BASE_HI: st_d.base_hi = wdata;
                SEL_ATTR:    st_d.attr    = wdata;
                default: ;
            endcase
        end

        if (clr_wr) begin
            st_d.fstat = '0;
            st_d.faddr = '0;
        end

        if (fault_valid && (new_flags != '0)) begin
            if (st_d.fstat == '0) begin
                st_d.faddr = fault_addr;
            end
            st_d.fstat = st_d.fstat | new_flags;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        case (sel)
            SEL_CTRL:     rd_word = {29'b0, st_q.inten, st_q.flush, st_q.en};
            SEL_XLCFG:    rd_word = st_q.xlcfg;
            SEL_BUSCFG:   rd_word = st_q.buscfg;
            SEL_BASE_LO:  rd_word = st_q.base_lo;
            SEL_BASE_HI:  rd_word = st_q.base_hi;
            SEL_FSTAT:    rd_word = {{(REG_W-FLAG_W){1'b0}}, st_q.fstat};
            SEL_ATTR:     rd_word = st_q.attr;
            SEL_FADDR_LO: rd_word = st_q.faddr[REG_W-1:0];
            SEL_FADDR_HI: rd_word = st_q.faddr[FADDR_W-1:REG_W];
            default:      rd_word = '0;
        endcase
        xlat_en = st_q.en;
        irq_req = st_q.inten && (st_q.fstat != '0);
    end

    assert_flush_start_R3: assert property (@(posedge clk) disable iff (!rst_n)
        flush_wr |=> st_q.flush);

    assert_flush_ends_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.flush && st_q.cnt == CNT_W'(1) && !flush_wr) |=> !st_q.flush);

    assert_unused_flag_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !st_q.fstat[3]);

    assert_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_wr && !fault_valid) |=> (st_q.fstat == '0 && st_q.faddr == '0));

    assert_nonzero_wr_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && sel == SEL_FSTAT && wdata != '0 && !fault_valid) |=> $stable(st_q.fstat));

    assert_addr_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.fstat != '0 && !clr_wr) |=> $stable(st_q.faddr));

endmodule

// File: rtl/xlat_ctx_regbank.sv
module xlat_ctx_regbank
    import xlat_ctx_pkg::*;
#(
    parameter int NUM_CTX   = 16,
    parameter int FLUSH_LAT = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [ADDR_W-1:0]  reg_addr,
    input  logic               reg_we,
    input  logic [REG_W-1:0]   reg_wdata,
    output logic [REG_W-1:0]   reg_rdata,
    input  logic [NUM_CTX-1:0] fault_valid,
    input  logic [FLAG_W-1:0]  fault_flags,
    input  logic [FADDR_W-1:0] fault_addr,
    output logic [NUM_CTX-1:0] ctx_xlat_en,
    output logic               irq
);

    logic               hit;
    logic [3:0]         ctx_idx;
    reg_sel_e           sel;
    logic [REG_W-1:0]   rd_words [NUM_CTX];
    logic [NUM_CTX-1:0] irq_reqs;
    logic [NUM_CTX-1:0] slot_sel;

    xlat_ctx_decode #(.NUM_CTX(NUM_CTX)) u_decode (
        .addr    (reg_addr),
        .hit     (hit),
        .ctx_idx (ctx_idx),
        .sel     (sel)
    );

    for (genvar i = 0; i < NUM_CTX; i++) begin : g_slot
        assign slot_sel[i] = hit && (ctx_idx == 4'(i));

        xlat_ctx_slot #(.FLUSH_LAT(FLUSH_LAT)) u_slot (
            .clk         (clk),
            .rst_n       (rst_n),
            .wr_en       (reg_we && slot_sel[i]),
            .sel         (sel),
            .wdata       (reg_wdata),
            .fault_valid (fault_valid[i]),
            .fault_flags (fault_flags),
            .fault_addr  (fault_addr),
            .rd_word     (rd_words[i]),
            .xlat_en     (ctx_xlat_en[i]),
            .irq_req     (irq_reqs[i])
        );
    end

    always_comb begin
        reg_rdata = '0;
        for (int i = 0; i < NUM_CTX; i++) begin
            if (slot_sel[i]) begin
                reg_rdata = reg_rdata | rd_words[i];
            end
        end
        irq = |irq_reqs;
    end

    assert_irq_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!irq && fault_valid == '0 && !reg_we) |=> !irq);

    assert_one_slot_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(slot_sel));

endmodule

// File: tb/xlat_ctx_regbank_bench.sv
`timescale 1ns/1ps
module xlat_ctx_regbank_bench;

    localparam int NCTX = 16;
    localparam int FLAT = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] reg_addr = '0;
    logic        reg_we = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [NCTX-1:0] fault_valid = '0;
    logic [4:0]  fault_flags = '0;
    logic [63:0] fault_addr = '0;
    logic [NCTX-1:0] ctx_xlat_en;
    logic        irq;

    always #2.5 clk = ~clk;

    xlat_ctx_regbank #(.NUM_CTX(NCTX), .FLUSH_LAT(FLAT)) u_xlat_ctx_regbank (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_we(reg_we),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .fault_valid(fault_valid),
        .fault_flags(fault_flags), .fault_addr(fault_addr),
        .ctx_xlat_en(ctx_xlat_en), .irq(irq)
    );

    int vectors = 0;
    int fails = 0;

    localparam int REG_OFF [9] = '{'h00, 'h08, 'h0C, 'h10, 'h14, 'h28, 'h20, 'h30, 'h34};
    localparam int GAP_OFF [7] = '{'h04, 'h18, 'h1C, 'h24, 'h2C, 'h38, 'h3C};

    logic [31:0] cfg_m [NCTX][5];
    bit          en_m  [NCTX];
    bit          ie_m  [NCTX];
    logic [4:0]  st_m  [NCTX];
    logic [63:0] fa_m  [NCTX];

    function automatic logic [11:0] a_of(int c, int off);
        int b;
        b = (c < 8) ? c * 'h40 : 'h800 + (c - 8) * 'h40;
        return 12'(b + off);
    endfunction

    function automatic logic [31:0] exp_rd(int c, int r);
        case (r)
            0: return {29'b0, ie_m[c], 1'b0, en_m[c]};
            1, 2, 3, 4, 5: return cfg_m[c][r-1];
            6: return {27'b0, st_m[c]};
            7: return fa_m[c][31:0];
            default: return fa_m[c][63:32];
        endcase
    endfunction

    function automatic bit exp_irq();
        bit x = 0;
        for (int c = 0; c < NCTX; c++) x |= ie_m[c] && (st_m[c] != 0);
        return x;
    endfunction

    function automatic logic [NCTX-1:0] exp_en();
        logic [NCTX-1:0] v = '0;
        for (int c = 0; c < NCTX; c++) v[c] = en_m[c];
        return v;
    endfunction

    task automatic model_fault(int c, logic [4:0] fl, logic [63:0] a);
        logic [4:0] f = fl & 5'b10111;
        if (f != 0) begin
            if (st_m[c] == 0) fa_m[c] = a;
            st_m[c] |= f;
        end
    endtask

    task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(logic [11:0] a, logic [31:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_we = 1'b1;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(logic [11:0] a, output logic [31:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic fault(int c, logic [4:0] fl, logic [63:0] a);
        @(negedge clk);
        fault_valid = '0; fault_valid[c] = 1'b1; fault_flags = fl; fault_addr = a;
        @(negedge clk);
        fault_valid = '0;
        model_fault(c, fl, a);
    endtask

    task automatic chk_reg(string tag, int c, int r);
        logic [31:0] d;
        rd(a_of(c, REG_OFF[r]), d);
        chk(tag, d, exp_rd(c, r));
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        logic [31:0] d;
        void'($urandom(32'd20240611));
        for (int c = 0; c < NCTX; c++) begin
            for (int r = 0; r < 5; r++) cfg_m[c][r] = '0;
            en_m[c] = 0; ie_m[c] = 0; st_m[c] = '0; fa_m[c] = '0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        for (int c = 0; c < NCTX; c += 5)
            for (int r = 0; r < 9; r++) chk_reg("R1 reset reg", c, r);
        chk("R1 enable out", ctx_xlat_en, '0);
        chk("R1 irq", irq, 0);

        // R8 window mapping, R10 config storage
        wr(a_of(9, 'h08), 32'hCAFE_0009);  cfg_m[9][0] = 32'hCAFE_0009;
        wr(a_of(1, 'h08), 32'h1111_0001);  cfg_m[1][0] = 32'h1111_0001;
        rd(12'h848, d); chk("R8 upper window ctx9", d, 32'hCAFE_0009);
        rd(12'h048, d); chk("R8 lower window ctx1", d, 32'h1111_0001);
        chk_reg("R10 ctx8 untouched", 8, 1);

        // R2 control bits
        wr(a_of(12, 0), 32'h5); en_m[12] = 1; ie_m[12] = 1;
        chk_reg("R2 ctrl readback", 12, 0);
        chk("R2 enable out", ctx_xlat_en, exp_en());

        // R3 flush timing
        wr(a_of(3, 0), 32'h2);
        reg_addr = a_of(3, 0);
        for (int k = 0; k < FLAT; k++) begin
            #1; chk("R3 flush pending", reg_rdata[1], 1);
            @(negedge clk);
        end
        #1; chk("R3 flush self-clear", reg_rdata[1], 0);
        wr(a_of(3, 0), 32'h2);
        wr(a_of(3, 0), 32'h0);
        rd(a_of(3, 0), d); chk("R3 zero write keeps flush", d[1], 1);
        repeat (FLAT) @(negedge clk);
        rd(a_of(3, 0), d); chk("R3 flush done", d, 0);

        // R4/R6 fault accumulation and address capture
        fault(5, 5'h01, 64'h0000_00AB_1234_5000);
        fault(5, 5'h12, 64'h0000_00CD_9999_0000);
        chk_reg("R4 status OR", 5, 6);
        chk("R4 status value", exp_rd(5, 6), 32'h13);
        chk_reg("R6 first address kept lo", 5, 7);
        chk_reg("R6 first address kept hi", 5, 8);
        fault(5, 5'h08, 64'h1);
        chk_reg("R4 bit3 only ignored", 5, 6);

        // R7 interrupt gating
        chk("R7 irq masked", irq, 0);
        wr(a_of(5, 0), 32'h4); ie_m[5] = 1;
        chk("R7 irq raised", irq, 1);

        // R5 clear semantics
        wr(a_of(5, 'h20), 32'h13);
        chk_reg("R5 nonzero write ignored", 5, 6);
        wr(a_of(5, 'h20), 32'h0); st_m[5] = 0; fa_m[5] = 0;
        chk_reg("R5 cleared", 5, 6);
        chk_reg("R6 address zero after clear", 5, 7);
        chk("R7 irq dropped", irq, 0);

        // R5 clear and fault in the same cycle: fault wins
        fault(6, 5'h04, 64'h77);
        @(negedge clk);
        reg_addr = a_of(6, 'h20); reg_wdata = 0; reg_we = 1'b1;
        fault_valid[6] = 1'b1; fault_flags = 5'h02; fault_addr = 64'h0000_0001_DEAD_BEE0;
        @(negedge clk);
        reg_we = 1'b0; fault_valid = '0;
        st_m[6] = 5'h02; fa_m[6] = 64'h0000_0001_DEAD_BEE0;
        chk_reg("R5 clear vs fault status", 6, 6);
        chk_reg("R6 clear vs fault addr lo", 6, 7);
        chk_reg("R6 clear vs fault addr hi", 6, 8);

        // R9 unmapped
        rd(12'h604, d); chk("R9 gap read", d, 0);
        wr(a_of(2, 'h09), 32'hFFFF_FFFF);
        chk_reg("R9 misaligned write ignored", 2, 1);

        // random mix
        for (int it = 0; it < 800; it++) begin
            int c = int'($urandom % NCTX);
            int op = int'($urandom % 7);
            logic [31:0] v = $urandom;
            case (op)
                0: begin
                    int r = int'($urandom % 5);
                    wr(a_of(c, REG_OFF[r+1]), v); cfg_m[c][r] = v;
                end
                1: chk_reg("R10 random readback", c, int'($urandom % 9));
                2: begin
                    logic [11:0] a;
                    case ($urandom % 3)
                        0: a = a_of(c, GAP_OFF[$urandom % 7]);
                        1: a = a_of(c, REG_OFF[$urandom % 9]) | 12'h200;
                        default: a = a_of(c, REG_OFF[$urandom % 9]) | 12'(1 + $urandom % 3);
                    endcase
                    wr(a, v);
                    rd(a, d); chk("R9 unmapped reads zero", d, 0);
                    chk_reg("R9 neighbour unchanged", c, 1 + int'($urandom % 5));
                end
                3: fault(c, 5'($urandom), {$urandom, $urandom});
                4: begin
                    wr(a_of(c, 0), v & 32'h5); en_m[c] = v[0]; ie_m[c] = v[2];
                    chk("R2 random enable out", ctx_xlat_en, exp_en());
                end
                5: if (v[0]) begin
                    wr(a_of(c, 'h20), v | 32'h1);
                    chk_reg("R5 random nonzero write", c, 6);
                end
                default: begin
                    wr(a_of(c, 'h20), 0); st_m[c] = 0; fa_m[c] = 0;
                    chk_reg("R6 random clear addr", c, 7);
                end
            endcase
            #1; chk("R7 random irq", irq, exp_irq());
        end
        for (int c = 0; c < NCTX; c++)
            for (int r = 0; r < 9; r++) chk_reg("R4 final sweep", c, r);

        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

endmodule